// File: doc/BRIEF.md
# Multi-Lane Receive Deskew Controller

This block supervises alignment of a bonded multi-lane receiver in which every lane buffers its data in an elastic FIFO. Each FIFO reports a partially-full and a partially-empty flag. The controller waits until the link is usable: the receiver reports ready, and every lane holds both block lock and frame lock. It then watches the order in which the FIFO flags settle. If some lane fills past its high mark while another lane is still below its low mark, the lanes are skewed beyond what the FIFOs can absorb. The controller then pulses a clear that makes the FIFOs realign, waits a settle interval and judges again.

When every lane shows neither flag in the same cycle, the lanes are aligned. The controller raises a done status and drives one read enable, copied to all lanes, so that the lanes advance together. Reads pause in any cycle in which any lane is near empty. A retry counter records failed attempts and raises a sticky error once a limit is reached. Losing the link drops the controller back to waiting.

States:
- `ST_IDLE`: waits for the link.
- `ST_CHECK`: judges the flags.
- `ST_CLEAR`: the one-cycle realign pulse.
- `ST_SETTLE`: the timed wait after a clear.
- `ST_ALIGNED`: reading.

Transitions:
- IDLE→CHECK when the link is up.
- CHECK→CLEAR on a fail verdict.
- CHECK→ALIGNED on a pass verdict.
- CLEAR→SETTLE always.
- SETTLE→CHECK when the timer expires.
- Any state→IDLE on link loss.

Top module: `lane_deskew_ctrl`

## Requirements
- R1: After synchronous active-high reset, `align_clr`, every bit of `fifo_rd_en`, `deskew_done` and `deskew_err` are low.
- R2: The controller leaves idle only in a cycle where `link_ready` is high and every bit of `lane_blk_lock` and `lane_frm_lock` is 1; until then it produces no clear, no read and no done.
- R3: While checking, a cycle in which at least one `fifo_pfull` bit and at least one `fifo_pempty` bit are 1 is a failure; `align_clr` is 1 for the cycle after that edge.
- R4: `align_clr` is high for exactly one cycle per failure. Flags are ignored for the following `SETTLE_CYCLES` cycles (default 16). Checking resumes in the cycle after those, so `deskew_done` cannot rise earlier than `SETTLE_CYCLES`+2 cycles after the pulse.
- R5: While checking, a cycle in which all `fifo_pfull` and all `fifo_pempty` bits are 0 completes alignment; `deskew_done` is 1 from the next cycle.
- R6: All bits of `fifo_rd_en` always carry the same value. They are 1 in a cycle where `deskew_done` is 1, the link is up and no `fifo_pempty` bit is set; this follows the flags within the same cycle.
- R7: While aligned, any set `fifo_pempty` bit forces `fifo_rd_en` to 0 in that cycle while `deskew_done` stays 1; reads resume once all such bits clear.
- R8: Loss of the link while aligned (ready low, or any lane's block or frame lock low) forces `fifo_rd_en` low in that cycle and clears `deskew_done` at the next edge; alignment must then be repeated.
- R9: Failures are counted from reset or from the last successful alignment, saturating at `RETRY_LIMIT` (default 8); `deskew_err` rises together with the `align_clr` pulse of the `RETRY_LIMIT`-th failure.
- R10: Once set, `deskew_err` stays 1 through link loss and further retries until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_ready | input | 1 | Receiver ready indication |
| lane_blk_lock | input | N_LANES | Per-lane block lock |
| lane_frm_lock | input | N_LANES | Per-lane frame lock |
| fifo_pfull | input | N_LANES | Per-lane FIFO partially-full flag |
| fifo_pempty | input | N_LANES | Per-lane FIFO partially-empty flag |
| align_clr | output | 1 | One-cycle realign clear to all lane FIFOs |
| fifo_rd_en | output | N_LANES | Common read enable, identical on every lane |
| deskew_done | output | 1 | Alignment complete |
| deskew_err | output | 1 | Sticky retry-limit error |

## Verification
Every state-derived output (`align_clr`, `deskew_done`, `deskew_err`) is due one clock edge after the flag pattern that causes it. The exception is the return to checking after a clear, which comes exactly `SETTLE_CYCLES`+1 edges after the pulse. `fifo_rd_en` additionally responds to `fifo_pempty` and link status in the same cycle. The bench drives each input pattern on the falling edge and queues the outputs expected just after the following rising edge. The monitor pops and compares one item one time unit after each rising edge, so same-cycle and next-edge results are both caught at the exact cycle.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_CLEAR,
        ST_SETTLE,
        ST_ALIGNED
    } dsk_state_t;

    typedef enum logic [1:0] {
        VERD_WAIT,
        VERD_FAIL,
        VERD_PASS
    } dsk_verdict_t;

endpackage

// File: rtl/dsk_flag_judge.sv
// Reduces per-lane status and FIFO flags into link health and a verdict.
module dsk_flag_judge
    import deskew_pkg::*;
#(
    parameter int N_LANES = 24
) (
    input  logic               link_ready,
    input  logic [N_LANES-1:0] lane_blk_lock,
    input  logic [N_LANES-1:0] lane_frm_lock,
    input  logic [N_LANES-1:0] fifo_pfull,
    input  logic [N_LANES-1:0] fifo_pempty,
    output logic               link_ok,
    output logic               any_empty,
    output dsk_verdict_t       verdict
);

    logic any_full;

    always_comb begin
        link_ok   = link_ready && (&lane_blk_lock) && (&lane_frm_lock);
        any_full  = |fifo_pfull;
        any_empty = |fifo_pempty;
        if (any_full && any_empty) begin
            verdict = VERD_FAIL;
        end else if (!any_full && !any_empty) begin
            verdict = VERD_PASS;
        end else begin
            verdict = VERD_WAIT;
        end
    end

endmodule

// File: rtl/dsk_settle_timer.sv
// Counts the settle interval while run is high; expired marks its last cycle.
module dsk_settle_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

endmodule

// File: rtl/dsk_retry_tracker.sv
// Saturating failure counter with a sticky limit error.
module dsk_retry_tracker #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic fail,
    input  logic success,
    output logic err
);

    localparam int RW = $clog2(LIMIT + 1);
    localparam logic [RW-1:0] CAP = RW'(LIMIT);

    logic [RW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            err <= 1'b0;
        end else begin
            if (success) begin
                cnt <= '0;
            end else if (fail && cnt != CAP) begin
                cnt <= cnt + 1'b1;
            end
            if (fail && (cnt + 1'b1 >= CAP)) begin
                err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/lane_deskew_ctrl.sv
// Top: deskew state machine for a bonded multi-lane receiver.
module lane_deskew_ctrl
    import deskew_pkg::*;
#(
    parameter int N_LANES       = 24,
    parameter int SETTLE_CYCLES = 16,
    parameter int RETRY_LIMIT   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               link_ready,
    input  logic [N_LANES-1:0] lane_blk_lock,
    input  logic [N_LANES-1:0] lane_frm_lock,
    input  logic [N_LANES-1:0] fifo_pfull,
    input  logic [N_LANES-1:0] fifo_pempty,
    output logic               align_clr,
    output logic [N_LANES-1:0] fifo_rd_en,
    output logic               deskew_done,
    output logic               deskew_err
);

    dsk_state_t   state, state_nxt;
    dsk_verdict_t verdict;
    logic         link_ok;
    logic         any_empty;
    logic         settle_done;
    logic         rd_common;
    logic         fail_evt;
    logic         pass_evt;

    dsk_flag_judge #(.N_LANES(N_LANES)) u_judge (
        .link_ready    (link_ready),
        .lane_blk_lock (lane_blk_lock),
        .lane_frm_lock (lane_frm_lock),
        .fifo_pfull    (fifo_pfull),
        .fifo_pempty   (fifo_pempty),
        .link_ok       (link_ok),
        .any_empty     (any_empty),
        .verdict       (verdict)
    );

    dsk_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_SETTLE),
        .expired (settle_done)
    );

    assign fail_evt = (state == ST_CHECK) && link_ok && (verdict == VERD_FAIL);
    assign pass_evt = (state == ST_CHECK) && link_ok && (verdict == VERD_PASS);

    dsk_retry_tracker #(.LIMIT(RETRY_LIMIT)) u_retry (
        .clk     (clk),
        .rst     (rst),
        .fail    (fail_evt),
        .success (pass_evt),
        .err     (deskew_err)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic; link loss has priority in every state
    always_comb begin
        state_nxt = state;
        if (!link_ok) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    state_nxt = ST_CHECK;
                ST_CHECK: begin
                    if (verdict == VERD_FAIL) begin
                        state_nxt = ST_CLEAR;
                    end else if (verdict == VERD_PASS) begin
                        state_nxt = ST_ALIGNED;
                    end
                end
                ST_CLEAR:   state_nxt = ST_SETTLE;
                ST_SETTLE: begin
                    if (settle_done) begin
                        state_nxt = ST_CHECK;
                    end
                end
                ST_ALIGNED: state_nxt = ST_ALIGNED;
                default:    state_nxt = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        align_clr   = 1'b0;
        deskew_done = 1'b0;
        rd_common   = 1'b0;
        unique case (state)
            ST_CLEAR:   align_clr = 1'b1;
            ST_ALIGNED: begin
                deskew_done = 1'b1;
                rd_common   = link_ok && !any_empty;
            end
            default: ;
        endcase
    end

    assign fifo_rd_en = {N_LANES{rd_common}};

endmodule

// File: rtl/lane_deskew_ctrl_chk.sv
// Property checker bound to the deskew controller.
module lane_deskew_ctrl_chk #(
    parameter int N_LANES = 24
) (
    input logic               clk,
    input logic               rst,
    input logic               link_ready,
    input logic [N_LANES-1:0] lane_blk_lock,
    input logic [N_LANES-1:0] lane_frm_lock,
    input logic [N_LANES-1:0] fifo_pfull,
    input logic [N_LANES-1:0] fifo_pempty,
    input logic               align_clr,
    input logic [N_LANES-1:0] fifo_rd_en,
    input logic               deskew_done,
    input logic               deskew_err
);

    logic lnk;
    assign lnk = link_ready && (&lane_blk_lock) && (&lane_frm_lock);

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        align_clr |=> !align_clr); // R4

    AST_CLR_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        !(align_clr && deskew_done)); // R3

    AST_DONE_AFTER_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(deskew_done) |-> $past(!(|fifo_pfull) && !(|fifo_pempty) && lnk)); // R5

    AST_RD_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
        (fifo_rd_en == '0) || (fifo_rd_en == '1)); // R6

    AST_RD_PAUSE: assert property (@(posedge clk) disable iff (rst)
        (|fifo_pempty) |-> (fifo_rd_en == '0)); // R7

    AST_LINK_LOSS: assert property (@(posedge clk) disable iff (rst)
        (deskew_done && !lnk) |=> !deskew_done); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        deskew_err |=> deskew_err); // R10

    AST_NO_START_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!deskew_done && !align_clr && !lnk) |=> (!deskew_done && !align_clr)); // R2

endmodule

bind lane_deskew_ctrl lane_deskew_ctrl_chk #(.N_LANES(N_LANES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .link_ready    (link_ready),
    .lane_blk_lock (lane_blk_lock),
    .lane_frm_lock (lane_frm_lock),
    .fifo_pfull    (fifo_pfull),
    .fifo_pempty   (fifo_pempty),
    .align_clr     (align_clr),
    .fifo_rd_en    (fifo_rd_en),
    .deskew_done   (deskew_done),
    .deskew_err    (deskew_err)
);

// File: tb/sim_lane_deskew_ctrl.sv
`timescale 1ns/1ps
module sim_lane_deskew_ctrl;

    localparam int N  = 24;
    localparam int SC = 16;
    localparam int RL = 8;
    localparam logic [N-1:0] ALL  = {N{1'b1}};
    localparam logic [N-1:0] NONE = '0;

    logic         clk = 1'b0;
    logic         rst;
    logic         link_ready;
    logic [N-1:0] lane_blk_lock, lane_frm_lock, fifo_pfull, fifo_pempty;
    logic         align_clr, deskew_done, deskew_err;
    logic [N-1:0] fifo_rd_en;

    typedef struct {
        logic  clr;
        logic  rd;
        logic  done;
        logic  err;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    lane_deskew_ctrl u0 (
        .clk           (clk),
        .rst           (rst),
        .link_ready    (link_ready),
        .lane_blk_lock (lane_blk_lock),
        .lane_frm_lock (lane_frm_lock),
        .fifo_pfull    (fifo_pfull),
        .fifo_pempty   (fifo_pempty),
        .align_clr     (align_clr),
        .fifo_rd_en    (fifo_rd_en),
        .deskew_done   (deskew_done),
        .deskew_err    (deskew_err)
    );

    // Driver: apply inputs, queue the outputs expected after the next rising edge
    task automatic drive(input logic r, input logic rdy,
                         input logic [N-1:0] bl, input logic [N-1:0] fr,
                         input logic [N-1:0] pf, input logic [N-1:0] pe,
                         input logic eclr, input logic erd,
                         input logic edone, input logic eerr, input string req);
        exp_t e;
        rst = r; link_ready = rdy;
        lane_blk_lock = bl; lane_frm_lock = fr;
        fifo_pfull = pf; fifo_pempty = pe;
        e.clr = eclr; e.rd = erd; e.done = edone; e.err = eerr; e.req = req;
        q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare one queued item just after every rising edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            logic [N-1:0] erd;
            e = q.pop_front();
            erd = e.rd ? ALL : NONE;
            n_checks++;
            if (align_clr !== e.clr || fifo_rd_en !== erd ||
                deskew_done !== e.done || deskew_err !== e.err) begin
                n_fail++;
                $display("FAIL %s: got clr=%b rd=%h done=%b err=%b, expected clr=%b rd=%h done=%b err=%b",
                         e.req, align_clr, fifo_rd_en, deskew_done, deskew_err,
                         e.clr, erd, e.done, e.err);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    logic [N-1:0] fr_drop;
    logic [N-1:0] one_pf;
    logic [N-1:0] some_pe;

    initial begin
        fr_drop = ALL;  fr_drop[0] = 1'b0;
        one_pf  = NONE; one_pf[3]  = 1'b1;
        some_pe = NONE; some_pe[5] = 1'b1; some_pe[17] = 1'b1;

        // R1: reset state
        drive(1, 0, NONE, NONE, NONE, NONE, 0, 0, 0, 0, "R1");
        drive(1, 1, ALL,  ALL,  NONE, NONE, 0, 0, 0, 0, "R1");
        // R2: no start without ready, nor with one lane lacking frame lock
        drive(0, 0, ALL, ALL,     NONE, NONE, 0, 0, 0, 0, "R2");
        drive(0, 1, ALL, fr_drop, NONE, NONE, 0, 0, 0, 0, "R2");
        drive(0, 1, NONE, ALL,    NONE, NONE, 0, 0, 0, 0, "R2");
        // enter check with all lanes near empty; stays waiting
        drive(0, 1, ALL, ALL, NONE, ALL,     0, 0, 0, 0, "R2");
        drive(0, 1, ALL, ALL, NONE, some_pe, 0, 0, 0, 0, "R5");
        // R3: one lane full while others still near empty
        drive(0, 1, ALL, ALL, one_pf, some_pe, 1, 0, 0, 0, "R3");
        // R4: clean flags during settle are ignored; 16 settle + 1 check cycle
        for (int i = 0; i < SC + 1; i++) begin
            drive(0, 1, ALL, ALL, NONE, NONE, 0, 0, 0, 0, "R4");
        end
        // R5 / R6: alignment complete, reads enabled on every lane
        drive(0, 1, ALL, ALL, NONE, NONE, 0, 1, 1, 0, "R5");
        drive(0, 1, ALL, ALL, NONE, NONE, 0, 1, 1, 0, "R6");
        // R7: pause on any near-empty lane, resume when clear
        drive(0, 1, ALL, ALL, NONE, some_pe, 0, 0, 1, 0, "R7");
        drive(0, 1, ALL, ALL, ALL,  NONE,    0, 1, 1, 0, "R6");
        drive(0, 1, ALL, ALL, NONE, NONE,    0, 1, 1, 0, "R7");
        // R8: frame-lock loss on lane 0
        drive(0, 1, ALL, fr_drop, NONE, NONE, 0, 0, 0, 0, "R8");
        drive(0, 1, ALL, fr_drop, NONE, NONE, 0, 0, 0, 0, "R8");
        // R9: repeated failures until the retry limit
        drive(0, 1, ALL, ALL, NONE, some_pe, 0, 0, 0, 0, "R9");
        for (int k = 0; k < RL; k++) begin
            drive(0, 1, ALL, ALL, one_pf, some_pe, 1, 0, 0, (k == RL - 1), "R9");
            for (int i = 0; i < SC + 1; i++) begin
                drive(0, 1, ALL, ALL, NONE, some_pe, 0, 0, 0, (k == RL - 1), "R9");
            end
        end
        // R10: error persists through further retry and link loss
        drive(0, 1, ALL, ALL, one_pf, some_pe, 1, 0, 0, 1, "R10");
        drive(0, 0, ALL, ALL, NONE, NONE,      0, 0, 0, 1, "R10");
        drive(0, 0, ALL, ALL, NONE, NONE,      0, 0, 0, 1, "R10");
        // R1: reset clears the sticky error
        drive(1, 1, ALL, ALL, NONE, NONE, 0, 0, 0, 0, "R1");
        drive(0, 1, ALL, ALL, NONE, some_pe, 0, 0, 0, 0, "R1");
        // R5: clean check after restart aligns again
        drive(0, 1, ALL, ALL, NONE, NONE, 0, 1, 1, 0, "R5");
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule